// File: doc/BRIEF.md
# RF Transmit Window Monitor

This block watches three transmitter control levels (RF drive, beam enable and receiver protection) and decides, once per inter-pulse period (IPP), whether the transmit timing stayed inside its safety envelope. Time is counted in 0.1 us units. A one-cycle `tick` enable supplies these units, and it is derived elsewhere from the system clock. The block checks each RF pulse and each beam-on interval for length when the interval ends. The IPP length and three on-time ratios are checked when the next period-start strobe arrives.

Every rule owns a sticky flag. Software clears a flag by writing ones to `clr_flags`, and `fault` reports whether any flag is set. The on-times and the IPP length of the last completed period are held on output registers so they can be read back. All limits are elaboration-time parameters. The duty ratios are compared by cross-multiplication, so no divider is built.

Top module: `txwin_guard`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `flags`, `fault` and all four measurement outputs read zero.
- R2: An RF pulse length is the number of ticks seen while `rf_on` is high. On the cycle where `rf_on` falls, a length below `RF_MIN` (default 5) sets `flags[0]`. A length of exactly `RF_MIN` does not.
- R3: On the falling edge of `rf_on`, a length above `RF_MAX` (default 20000) sets `flags[1]`. The pulse counter saturates at `RF_MAX+1`.
- R4: On the falling edge of `beam_on`, a beam interval above `BEAM_MAX` ticks (default 20000) sets `flags[2]`.
- R5: At an `ipp_start` strobe, a period shorter than `IPP_MIN` ticks (default 5000) sets `flags[3]`. A period of exactly `IPP_MIN` does not.
- R6: The period counter saturates at `IPP_MAX+1` and never wraps. While the counter holds that value after the first strobe, `flags[4]` is set every cycle.
- R7: At a strobe, `flags[5]` is set when RF on-time × 1000 is below `RF_DUTY_LO` × IPP or above `RF_DUTY_HI` × IPP. The limits are in tenths of a percent (defaults 1 and 250), and both bounds are inclusive.
- R8: At a strobe, `flags[6]` is set when beam on-time × 1000 lies outside [`BEAM_DUTY_LO` × IPP, `BEAM_DUTY_HI` × IPP] (defaults 1 and 250).
- R9: At a strobe, `flags[7]` is set when protect on-time × 1000 exceeds `PROT_DUTY_HI` × IPP (default 400).
- R10: On a strobe cycle, the accumulated period counts are copied to `rf_time`, `beam_time`, `prot_time` and `ipp_time`, and the accumulators restart from zero. A tick in the strobe cycle itself is not counted. The outputs change only on strobe cycles.
- R11: A one in `clr_flags[i]` clears `flags[i]` on the next edge. A new violation of rule i in the same cycle wins over the clear. A flag otherwise holds.
- R12: `fault` is the OR of `flags` and updates on the same edge.
- R13: The checks of R5 to R9 are skipped at the first strobe after reset, because no complete period exists yet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle 0.1 us time unit enable |
| ipp_start | input | 1 | Period-start strobe |
| rf_on | input | 1 | RF drive level |
| beam_on | input | 1 | Beam enable level |
| rxprot | input | 1 | Receiver protection level |
| clr_flags | input | 8 | Write-one-to-clear per flag |
| flags | output | 8 | Sticky violation flags, bit order per R2–R9 |
| fault | output | 1 | OR of all flags |
| rf_time | output | CW | RF on-time of last period, ticks |
| beam_time | output | CW | Beam on-time of last period, ticks |
| prot_time | output | CW | Protect on-time of last period, ticks |
| ipp_time | output | CW | Length of last period, ticks (saturated) |

## Verification
The bench aims at each boundary from both sides: pulses of exactly `RF_MIN` and one tick less, `RF_MAX` and one tick more, periods at `IPP_MIN` and just under it, and duty ratios landing exactly on a limit. A design that used the wrong comparison operator would flag these legal boundary cases, or miss the failing ones. A saturating period with a clear issued during saturation catches a wrapping counter (it would report a small `ipp_time`) and a clear-wins priority (it would drop `flags[4]`). A short first period checks that nothing fires before the block is armed. A design that counted the strobe-cycle tick would be one tick off in every measurement.

// File: rtl/txwin_pkg.sv
package txwin_pkg;
  localparam int NFLAG = 8;
  localparam int NCHAN = 3;

  // channel index of the period accumulators
  localparam int CH_RF   = 0;
  localparam int CH_BEAM = 1;
  localparam int CH_PROT = 2;

  // flag bit positions (software decodes these)
  localparam int FL_RF_SHORT   = 0;
  localparam int FL_RF_LONG    = 1;
  localparam int FL_BEAM_LONG  = 2;
  localparam int FL_IPP_SHORT  = 3;
  localparam int FL_IPP_LONG   = 4;
  localparam int FL_RF_DUTY    = 5;
  localparam int FL_BEAM_DUTY  = 6;
  localparam int FL_PROT_DUTY  = 7;

  // duty limits are in tenths of a percent
  localparam int DUTY_SCALE = 1000;
endpackage

// File: rtl/txwin_satcnt.sv
module txwin_satcnt #(
  parameter int W   = 8,
  parameter int SAT = 255
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] TOP = W'(SAT);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (inc && (cnt != TOP)) begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/txwin_ratio.sv
module txwin_ratio import txwin_pkg::*; #(
  parameter int W  = 8,
  parameter int LO = 1,
  parameter int HI = 250
) (
  input  logic [W-1:0] on_time,
  input  logic [W-1:0] span,
  output logic         below,
  output logic         above
);
  // 1000 < 2^10, limits < 2^10: 11 extra bits cover both products
  localparam int MW = W + 11;

  logic [MW-1:0] on_x, lo_x, hi_x;

  always_comb begin
    on_x  = MW'(on_time) * MW'(DUTY_SCALE);
    lo_x  = MW'(span) * MW'(LO);
    hi_x  = MW'(span) * MW'(HI);
    below = (on_x < lo_x);
    above = (on_x > hi_x);
  end
endmodule

// File: rtl/txwin_guard.sv
module txwin_guard import txwin_pkg::*; #(
  parameter int RF_MIN       = 5,
  parameter int RF_MAX       = 20000,
  parameter int BEAM_MAX     = 20000,
  parameter int IPP_MIN      = 5000,
  parameter int IPP_MAX      = 500000,
  parameter int RF_DUTY_LO   = 1,
  parameter int RF_DUTY_HI   = 250,
  parameter int BEAM_DUTY_LO = 1,
  parameter int BEAM_DUTY_HI = 250,
  parameter int PROT_DUTY_HI = 400,
  localparam int CW = $clog2(IPP_MAX + 2)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             ipp_start,
  input  logic             rf_on,
  input  logic             beam_on,
  input  logic             rxprot,
  input  logic [NFLAG-1:0] clr_flags,
  output logic [NFLAG-1:0] flags,
  output logic             fault,
  output logic [CW-1:0]    rf_time,
  output logic [CW-1:0]    beam_time,
  output logic [CW-1:0]    prot_time,
  output logic [CW-1:0]    ipp_time
);
  localparam int RSAT = RF_MAX + 1;
  localparam int RW   = $clog2(RF_MAX + 2);
  localparam int BSAT = BEAM_MAX + 1;
  localparam int BW   = $clog2(BEAM_MAX + 2);
  localparam int ISAT = IPP_MAX + 1;
  localparam int LO_TAB [NCHAN] = '{RF_DUTY_LO, BEAM_DUTY_LO, 0};
  localparam int HI_TAB [NCHAN] = '{RF_DUTY_HI, BEAM_DUTY_HI, PROT_DUTY_HI};

  logic [NCHAN-1:0] lvl;
  logic             rf_d, beam_d, armed;
  logic             rf_fall, beam_fall, checking;
  logic [RW-1:0]    rf_len;
  logic [BW-1:0]    beam_len;
  logic [CW-1:0]    ipp_cnt;
  logic [CW-1:0]    acc [NCHAN];
  logic [NCHAN-1:0] below, above;
  logic [NFLAG-1:0] ev, flags_d;

  assign lvl       = {rxprot, beam_on, rf_on};
  assign rf_fall   = rf_d & ~rf_on;
  assign beam_fall = beam_d & ~beam_on;
  assign checking  = ipp_start & armed;

  // single-interval length counters, restarted at the falling edge
  txwin_satcnt #(.W(RW), .SAT(RSAT)) u_rf_len (
    .clk(clk), .rst(rst), .clr(rf_fall), .inc(tick & rf_on), .cnt(rf_len)
  );

  txwin_satcnt #(.W(BW), .SAT(BSAT)) u_beam_len (
    .clk(clk), .rst(rst), .clr(beam_fall), .inc(tick & beam_on), .cnt(beam_len)
  );

  // period length, saturating one past the upper bound
  txwin_satcnt #(.W(CW), .SAT(ISAT)) u_ipp (
    .clk(clk), .rst(rst), .clr(ipp_start), .inc(tick), .cnt(ipp_cnt)
  );

  // per-channel period on-time and ratio comparison
  for (genvar g = 0; g < NCHAN; g++) begin : g_chan
    txwin_satcnt #(.W(CW), .SAT(ISAT)) u_acc (
      .clk(clk), .rst(rst), .clr(ipp_start), .inc(tick & lvl[g]), .cnt(acc[g])
    );
    txwin_ratio #(.W(CW), .LO(LO_TAB[g]), .HI(HI_TAB[g])) u_ratio (
      .on_time(acc[g]), .span(ipp_cnt), .below(below[g]), .above(above[g])
    );
  end

  always_comb begin
    ev = '0;
    ev[FL_RF_SHORT]  = rf_fall & (rf_len < RW'(RF_MIN));
    ev[FL_RF_LONG]   = rf_fall & (rf_len > RW'(RF_MAX));
    ev[FL_BEAM_LONG] = beam_fall & (beam_len > BW'(BEAM_MAX));
    ev[FL_IPP_SHORT] = checking & (ipp_cnt < CW'(IPP_MIN));
    ev[FL_IPP_LONG]  = armed & (ipp_cnt == CW'(ISAT));
    ev[FL_RF_DUTY]   = checking & (below[CH_RF] | above[CH_RF]);
    ev[FL_BEAM_DUTY] = checking & (below[CH_BEAM] | above[CH_BEAM]);
    ev[FL_PROT_DUTY] = checking & (below[CH_PROT] | above[CH_PROT]);
    flags_d = (flags & ~clr_flags) | ev;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags     <= '0;
      fault     <= 1'b0;
      rf_d      <= 1'b0;
      beam_d    <= 1'b0;
      armed     <= 1'b0;
      rf_time   <= '0;
      beam_time <= '0;
      prot_time <= '0;
      ipp_time  <= '0;
    end else begin
      flags  <= flags_d;
      fault  <= |flags_d;
      rf_d   <= rf_on;
      beam_d <= beam_on;
      armed  <= armed | ipp_start;
      if (ipp_start) begin
        rf_time   <= acc[CH_RF];
        beam_time <= acc[CH_BEAM];
        prot_time <= acc[CH_PROT];
        ipp_time  <= ipp_cnt;
      end
    end
  end
endmodule

// File: rtl/txwin_guard_chk.sv
module txwin_guard_chk #(
  parameter int NF   = 8,
  parameter int CW   = 8,
  parameter int ISAT = 255
) (
  input logic          clk,
  input logic          rst,
  input logic          ipp_start,
  input logic [NF-1:0] clr_flags,
  input logic [NF-1:0] flags,
  input logic          fault,
  input logic [CW-1:0] rf_time,
  input logic [CW-1:0] ipp_time
);
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (flags == '0) && !fault);

  a_r11_sticky: assert property (@(posedge clk) disable iff (rst)
    ((~flags & $past(flags & ~clr_flags)) == '0));

  a_r12_fault_or: assert property (@(posedge clk) disable iff (rst)
    fault == (flags != '0));

  a_r6_no_wrap: assert property (@(posedge clk) disable iff (rst)
    ipp_time <= CW'(ISAT));

  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    !ipp_start |=> $stable(ipp_time) && $stable(rf_time));

  a_r7_on_within_span: assert property (@(posedge clk) disable iff (rst)
    rf_time <= ipp_time);
endmodule

bind txwin_guard txwin_guard_chk #(.NF(txwin_pkg::NFLAG), .CW(CW), .ISAT(IPP_MAX + 1)) u_chk (
  .clk(clk), .rst(rst), .ipp_start(ipp_start), .clr_flags(clr_flags),
  .flags(flags), .fault(fault), .rf_time(rf_time), .ipp_time(ipp_time)
);

// File: tb/sim_txwin_guard.sv
`timescale 1ns/100ps
module sim_txwin_guard;
  localparam int P_RF_MIN = 5, P_RF_MAX = 40, P_BEAM_MAX = 50;
  localparam int P_IPP_MIN = 100, P_IPP_MAX = 400;
  localparam int CW = $clog2(P_IPP_MAX + 2);

  logic clk = 1'b0, rst = 1'b1, tick = 1'b1, ipp_start = 1'b0;
  logic rf_on = 1'b0, beam_on = 1'b0, rxprot = 1'b0;
  logic [7:0] clr_flags = '0;
  logic [7:0] flags;
  logic fault;
  logic [CW-1:0] rf_time, beam_time, prot_time, ipp_time;

  int compared = 0, mismatched = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  txwin_guard #(
    .RF_MIN(P_RF_MIN), .RF_MAX(P_RF_MAX), .BEAM_MAX(P_BEAM_MAX),
    .IPP_MIN(P_IPP_MIN), .IPP_MAX(P_IPP_MAX)
  ) u0 (
    .clk(clk), .rst(rst), .tick(tick), .ipp_start(ipp_start),
    .rf_on(rf_on), .beam_on(beam_on), .rxprot(rxprot), .clr_flags(clr_flags),
    .flags(flags), .fault(fault), .rf_time(rf_time), .beam_time(beam_time),
    .prot_time(prot_time), .ipp_time(ipp_time)
  );

  // ---------------- behavioural reference ----------------
  int m_rlen, m_blen, m_ipp, m_rf, m_bm, m_pr;
  int o_rf, o_bm, o_pr, o_ipp;
  bit m_rfd, m_bmd, m_armed;
  bit [7:0] m_flags;

  function automatic bit outside(int on, int span, int lo, int hi);
    longint a = longint'(on) * 1000;
    return (a < longint'(lo) * span) || (a > longint'(hi) * span);
  endfunction

  always @(posedge clk) begin
    bit fr, fb, chk;
    bit [7:0] ev;
    if (rst) begin
      m_rlen = 0; m_blen = 0; m_ipp = 0; m_rf = 0; m_bm = 0; m_pr = 0;
      o_rf = 0; o_bm = 0; o_pr = 0; o_ipp = 0;
      m_rfd = 0; m_bmd = 0; m_armed = 0; m_flags = 0;
    end else begin
      fr = m_rfd && !rf_on;
      fb = m_bmd && !beam_on;
      chk = ipp_start && m_armed;
      ev = 0;
      ev[0] = fr && (m_rlen < P_RF_MIN);
      ev[1] = fr && (m_rlen > P_RF_MAX);
      ev[2] = fb && (m_blen > P_BEAM_MAX);
      ev[3] = chk && (m_ipp < P_IPP_MIN);
      ev[4] = m_armed && (m_ipp == P_IPP_MAX + 1);
      ev[5] = chk && outside(m_rf, m_ipp, 1, 250);
      ev[6] = chk && outside(m_bm, m_ipp, 1, 250);
      ev[7] = chk && outside(m_pr, m_ipp, 0, 400);
      m_flags = (m_flags & ~clr_flags) | ev;
      if (ipp_start) begin
        o_rf = m_rf; o_bm = m_bm; o_pr = m_pr; o_ipp = m_ipp;
        m_ipp = 0; m_rf = 0; m_bm = 0; m_pr = 0;
      end else if (tick) begin
        if (m_ipp < P_IPP_MAX + 1) m_ipp++;
        if (rf_on && m_rf < P_IPP_MAX + 1) m_rf++;
        if (beam_on && m_bm < P_IPP_MAX + 1) m_bm++;
        if (rxprot && m_pr < P_IPP_MAX + 1) m_pr++;
      end
      if (fr) m_rlen = 0; else if (tick && rf_on && m_rlen < P_RF_MAX + 1) m_rlen++;
      if (fb) m_blen = 0; else if (tick && beam_on && m_blen < P_BEAM_MAX + 1) m_blen++;
      m_rfd = rf_on;
      m_bmd = beam_on;
      m_armed = m_armed || ipp_start;
    end
  end

  // ---------------- checking ----------------
  string FTAG [8] = '{"R2 rf_short", "R3 rf_long", "R4 beam_long", "R5 ipp_short",
                      "R6 ipp_long", "R7 rf_duty", "R8 beam_duty", "R9 prot_duty"};

  task automatic cmp(input string tag, input longint act, input longint exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    for (int i = 0; i < 8; i++) cmp(FTAG[i], flags[i], m_flags[i]);
    cmp("R12 fault", fault, m_flags != 0);
    cmp("R10 rf_time", rf_time, o_rf);
    cmp("R10 beam_time", beam_time, o_bm);
    cmp("R10 prot_time", prot_time, o_pr);
    cmp("R10 ipp_time", ipp_time, o_ipp);
  endtask

  task automatic cycle();
    @(negedge clk);
    compare_all();
  endtask

  // clears all flags on its first cycle, then strobes after total cycles
  task automatic period(input int total, input int rfw, input int bw, input int pw);
    for (int c = 0; c < total; c++) begin
      clr_flags = (c == 0) ? 8'hFF : 8'h00;
      rf_on = (c < rfw); beam_on = (c < bw); rxprot = (c < pw);
      cycle();
    end
    clr_flags = 0; rf_on = 0; beam_on = 0; rxprot = 0;
    ipp_start = 1;
    cycle();
    ipp_start = 0;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  initial begin
    repeat (3) cycle();
    cmp("R1 flags in reset", flags, 0);
    cmp("R1 ipp_time in reset", ipp_time, 0);
    rst = 0;
    cycle();
    cmp("R1 fault after reset", fault, 0);

    // R13: short first period with no RF must not flag
    repeat (20) cycle();
    ipp_start = 1; cycle(); ipp_start = 0;
    cmp("R13 first strobe unchecked", flags, 0);

    period(200, 10, 20, 40);
    cmp("R7 clean period", flags, 0);
    cmp("R10 rf_time value", rf_time, 10);
    cmp("R10 ipp_time excludes strobe tick", ipp_time, 200);

    period(200, 4, 20, 40);  cmp("R2 four-tick pulse", flags, 8'h01);
    period(200, 5, 20, 40);  cmp("R2 min pulse legal", flags, 8'h00);
    period(200, 41, 20, 40); cmp("R3 pulse over max", flags, 8'h02);
    period(200, 40, 20, 40); cmp("R3 max pulse legal", flags, 8'h00);
    period(220, 10, 51, 40); cmp("R4 beam over max", flags, 8'h04);
    period(99, 10, 20, 30);  cmp("R5 ipp below min", flags, 8'h08);
    period(100, 10, 20, 30); cmp("R5 ipp at min", flags, 8'h00);
    period(200, 0, 20, 40);  cmp("R7 rf duty zero", flags, 8'h20);
    period(100, 26, 10, 10); cmp("R7 rf duty above", flags, 8'h20);
    period(100, 25, 10, 10); cmp("R7 rf duty at limit", flags, 8'h00);
    period(100, 10, 26, 10); cmp("R8 beam duty above", flags, 8'h40);
    period(100, 10, 10, 41); cmp("R9 prot duty above", flags, 8'h80);
    period(100, 10, 10, 40); cmp("R9 prot duty at limit", flags, 8'h00);
    cmp("R12 fault clear", fault, 0);

    period(200, 4, 20, 40);
    cmp("R12 fault set", fault, 1);
    clr_flags = 8'hFF; cycle(); clr_flags = 0;
    cmp("R11 clear", flags, 0);

    // R6: run with no strobe until the period counter saturates
    for (int c = 0; c < 420; c++) begin
      clr_flags = (c == 410) ? 8'h10 : 8'h00;
      cycle();
    end
    clr_flags = 0;
    cmp("R11 set wins over clear", flags[4], 1);
    ipp_start = 1; cycle(); ipp_start = 0;
    cmp("R6 saturated ipp no wrap", ipp_time, P_IPP_MAX + 1);

    // mixed traffic compared against the reference every cycle
    for (int c = 0; c < 3000; c++) begin
      tick      = ($urandom_range(1, 0) == 1);
      rf_on     = ($urandom_range(9, 0) < 2);
      beam_on   = ($urandom_range(9, 0) < 3);
      rxprot    = ($urandom_range(9, 0) < 4);
      ipp_start = ($urandom_range(149, 0) == 0);
      clr_flags = ($urandom_range(49, 0) == 0) ? 8'($urandom) : 8'h00;
      cycle();
    end

    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end
endmodule